// File: doc/BRIEF.md
# Cache Tag Store with Tag Comparator

This block keeps one tag per line of a direct-mapped cache and tells the cache controller, in one clock, whether the tag held for a line equals a tag presented on the data bus. It holds 8192 entries of 8 bits, selected by a 13-bit line index. For a 20-bit byte address the low 13 bits pick the line and the upper 7 bits form the page tag, so a 1 MB space folds onto 8K lines. The tag goes on the 8-bit data bus, with one bit spare.

One port serves four functions, and four active-low controls pick among them: compare, read, write and clear of the whole array. The clear is a sweep that writes zero into one entry per clock. While the sweep runs the block reports busy and ignores every request. The match result leaves the block as a pull-down enable, so several of these stores can share one wired-AND match line to build a wider tag. A plain high-true match copy comes out as well.

Top module: `tag_store_cmp`

## Requirements
- R1: With `ce_n` high and no sweep running, nothing is written, `dout_en` is 0 the next cycle and `match` is 1.
- R2: Compare is `ce_n`=0, `we_n`=1, `oe_n`=1 and `clr_n`=1. One cycle after the request, `match` is 1 if `din` equals the entry at `idx`, and 0 if it does not.
- R3: Read is `ce_n`=0, `oe_n`=0, `we_n`=1 and `clr_n`=1. One cycle later `dout` carries the entry at `idx`, `dout_en` is 1 and `match` is 1.
- R4: Write is `ce_n`=0 and `we_n`=0, with `oe_n` not looked at. The entry at `idx` takes `din`. The next cycle `match` is 1 and `dout_en` is 0.
- R5: `clr_n`=0 outranks every other control when the block is idle. It starts a sweep during which `busy` is 1 for exactly 8192 cycles. Afterwards every entry reads 0.
- R6: While `busy` is 1, every request is ignored. No write lands, `match` is 1 and `dout_en` is 0. A compare or write that comes in the same cycle as `clr_n`=0 is ignored too.
- R7: After synchronous reset, `busy` is 0, `match` is 1, `match_pd` is 0 and `dout_en` is 0.
- R8: `match_pd` is 1 exactly when `match` is 0. This is the pull-down enable for a shared wired-AND match line.
- R9: Index 0 and index 8191 are separate entries. A write to one leaves the other as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low (selects read) |
| we_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Clear-all request, active low |
| idx | input | 13 | Line index |
| din | input | 8 | Tag to compare or data to write |
| dout | output | 8 | Read data, zero when not valid |
| dout_en | output | 1 | Read data valid, the flag that would drive the bus |
| match | output | 1 | Compare result, high outside compare |
| match_pd | output | 1 | Pull-down enable for a wired-AND match line |
| busy | output | 1 | Clear sweep in progress |

## Verification
Two things can land in the same cycle: a clear request and a compare or write. The sweep can also still be running when a new request arrives. The bench pulls `clr_n` low in the same cycle as a compare whose tag is known not to match, and expects `match` to stay high the next cycle. During the sweep it drives a write and a compare, and afterwards it checks that the written entry still reads zero and that `busy` lasted exactly the array depth.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_CMP   = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_t;
endpackage

// File: rtl/tagcmp_decode.sv
module tagcmp_decode
  import tagcmp_pkg::*;
(
  input  logic busy,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic clr_n,
  output logic clr_start,
  output op_t  op
);
  // Clear outranks every other control; while sweeping everything is dropped.
  always_comb begin
    clr_start = !busy && !clr_n;
    if (busy || !clr_n || ce_n) op = OP_IDLE;
    else if (!we_n)             op = OP_WRITE;
    else if (!oe_n)             op = OP_READ;
    else                        op = OP_CMP;
  end
endmodule

// File: rtl/tagcmp_sweep.sv
module tagcmp_sweep #(
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] ptr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      ptr  <= '0;
    end
  end
endmodule

// File: rtl/tagcmp_array.sv
module tagcmp_array #(
  parameter int IDX_W = 13,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [TAG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [TAG_W-1:0] rd_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/tag_store_cmp.sv
module tag_store_cmp
  import tagcmp_pkg::*;
#(
  parameter int IDX_W = 13,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             clr_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] din,
  output logic [TAG_W-1:0] dout,
  output logic             dout_en,
  output logic             match,
  output logic             match_pd,
  output logic             busy
);
  op_t              op_now, op_q;
  logic             clr_start;
  logic [IDX_W-1:0] sweep_ptr;
  logic [TAG_W-1:0] din_q, rd_q;
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [TAG_W-1:0] wr_data;

  tagcmp_decode u_decode (
    .busy(busy), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .clr_n(clr_n),
    .clr_start(clr_start), .op(op_now)
  );

  tagcmp_sweep #(.IDX_W(IDX_W)) u_sweep (
    .clk(clk), .rst(rst), .start(clr_start), .busy(busy), .ptr(sweep_ptr)
  );

  // The sweep owns the write port while busy; otherwise a write request does.
  always_comb begin
    wr_en   = busy || (op_now == OP_WRITE);
    wr_addr = busy ? sweep_ptr : idx;
    wr_data = busy ? '0 : din;
  end

  tagcmp_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(idx), .rd_q(rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_IDLE;
      din_q <= '0;
    end else begin
      op_q  <= op_now;
      din_q <= din;
    end
  end

  always_comb begin
    match_pd = (op_q == OP_CMP) && (rd_q != din_q);
    match    = !match_pd;
    dout_en  = (op_q == OP_READ);
    dout     = dout_en ? rd_q : '0;
  end
endmodule

// File: rtl/tagcmp_chk.sv
module tagcmp_chk #(
  parameter int IDX_W = 13
) (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic clr_n,
  input logic busy,
  input logic match,
  input logic match_pd,
  input logic dout_en
);
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && clr_n && ce_n) |=> (match && !dout_en));

  assert_read_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && clr_n && !ce_n && !oe_n && we_n) |=> (dout_en && match));

  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && clr_n && !ce_n && !we_n) |=> (match && !dout_en));

  assert_clear_starts_R5: assert property (@(posedge clk) disable iff (rst)
    (!busy && !clr_n) |=> busy);

  assert_sweep_length_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == (IDX_W+1)'(DEPTH)));

  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (rst)
    (busy || !clr_n) |=> (match && !dout_en));

  assert_pulldown_R8: assert property (@(posedge clk) disable iff (rst)
    match_pd |-> (!match && !dout_en));
endmodule

bind tag_store_cmp tagcmp_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .clr_n(clr_n), .busy(busy), .match(match), .match_pd(match_pd),
  .dout_en(dout_en)
);

// File: tb/tag_store_cmp_bench.sv
module tag_store_cmp_bench;
  localparam int IDX_W = 13;
  localparam int TAG_W = 8;
  localparam int DEPTH = 1 << IDX_W;
  localparam int VW    = 3 + IDX_W + TAG_W + 2 + TAG_W;
  localparam int NV    = 13;

  // {ce_n, oe_n, we_n, idx, din, exp_en, exp_match, exp_dout}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'b000, 13'd0,    8'h3C, 1'b0, 1'b1, 8'h00}, // R4 write, oe_n low ignored
    {3'b010, 13'd8191, 8'hC3, 1'b0, 1'b1, 8'h00}, // R4/R9 top index
    {3'b010, 13'd100,  8'h7F, 1'b0, 1'b1, 8'h00}, // R4
    {3'b011, 13'd0,    8'h3C, 1'b0, 1'b1, 8'h00}, // R2 hit
    {3'b011, 13'd0,    8'h3D, 1'b0, 1'b0, 8'h00}, // R2 miss by one bit
    {3'b011, 13'd8191, 8'hC3, 1'b0, 1'b1, 8'h00}, // R2/R9 hit
    {3'b011, 13'd8191, 8'h3C, 1'b0, 1'b0, 8'h00}, // R2/R9 miss
    {3'b001, 13'd0,    8'h00, 1'b1, 1'b1, 8'h3C}, // R3/R9 read
    {3'b001, 13'd8191, 8'h00, 1'b1, 1'b1, 8'hC3}, // R3 read
    {3'b100, 13'd100,  8'h00, 1'b0, 1'b1, 8'h00}, // R1 deselected write attempt
    {3'b001, 13'd100,  8'h00, 1'b1, 1'b1, 8'h7F}, // R1 entry untouched
    {3'b011, 13'd1,    8'h00, 1'b0, 1'b1, 8'h00}, // R5 cleared entry hits zero
    {3'b011, 13'd100,  8'h7F, 1'b0, 1'b1, 8'h00}  // R2 hit
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, clr_n = 1'b1;
  logic [IDX_W-1:0] idx = '0;
  logic [TAG_W-1:0] din = '0;
  logic [TAG_W-1:0] dout;
  logic             dout_en, match, match_pd, busy;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  tag_store_cmp #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag_store_cmp (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .clr_n(clr_n), .idx(idx), .din(din), .dout(dout), .dout_en(dout_en),
    .match(match), .match_pd(match_pd), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic o, input logic w, input logic cl,
                       input int i, input int d);
    ce_n = c; oe_n = o; we_n = w; clr_n = cl;
    idx = IDX_W'(i); din = TAG_W'(d);
  endtask

  // One operation: drive at a falling edge, result visible at the next one.
  task automatic op_step(input logic c, input logic o, input logic w, input int i, input int d);
    drive(c, o, w, 1'b1, i, d);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 0, 0);
  endtask

  task automatic run_clear(input string req, output int len);
    len = 0;
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    while (busy && len < DEPTH + 10) begin
      len++;
      if (len == 10) drive(1'b0, 1'b1, 1'b0, 1'b1, 5, 8'hAA);  // write while busy
      if (len == 20) drive(1'b0, 1'b1, 1'b1, 1'b1, 5, 8'hAA);  // compare while busy
      if (len == 11 || len == 21) begin
        chk({req, " R6 match during sweep"}, match, 1);
        chk({req, " R6 dout_en during sweep"}, dout_en, 0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 0, 0);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int len;
    logic [VW-1:0] v;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 busy", busy, 0);
    chk("R7 match", match, 1);
    chk("R7 match_pd", match_pd, 0);
    chk("R7 dout_en", dout_en, 0);
    rst = 1'b0;
    @(negedge clk);

    run_clear("R5 first clear", len);
    chk("R5 busy length", len, DEPTH);
    op_step(1'b0, 1'b0, 1'b1, 5, 0);
    chk("R6 write during sweep dropped", dout, 0);
    chk("R6 read flag", dout_en, 1);

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      op_step(v[VW-1], v[VW-2], v[VW-3], int'(v[VW-4 -: IDX_W]),
              int'(v[2*TAG_W+1 -: TAG_W]));
      chk($sformatf("R1-table vec%0d dout_en", k), dout_en, int'(v[TAG_W+1]));
      chk($sformatf("R2 vec%0d match", k), match, int'(v[TAG_W]));
      chk($sformatf("R8 vec%0d match_pd", k), match_pd, int'(!v[TAG_W]));
      chk($sformatf("R3 vec%0d dout", k), dout, int'(v[TAG_W-1:0]));
    end

    // R6: clear requested together with a mismatching compare
    drive(1'b0, 1'b1, 1'b1, 1'b0, 0, 8'h11);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b1, 1'b1, 0, 0);
    chk("R6 compare with clear, match", match, 1);
    chk("R6 compare with clear, match_pd", match_pd, 0);
    chk("R5 busy after clear request", busy, 1);
    len = 1;
    while (busy && len < DEPTH + 10) begin
      @(negedge clk);
      if (busy) len++;
    end
    chk("R5 second busy length", len, DEPTH);
    op_step(1'b0, 1'b0, 1'b1, 0, 0);
    chk("R5 idx0 cleared", dout, 0);
    op_step(1'b0, 1'b0, 1'b1, 8191, 0);
    chk("R5 idx8191 cleared", dout, 0);
    op_step(1'b0, 1'b1, 1'b1, 8191, 8'hC3);
    chk("R2 old tag now misses", match, 0);

    // R9: write top index, bottom index keeps its value
    op_step(1'b0, 1'b1, 1'b0, 0, 8'h5A);
    op_step(1'b0, 1'b1, 1'b0, 8191, 8'hA5);
    op_step(1'b0, 1'b0, 1'b1, 0, 0);
    chk("R9 idx0 kept", dout, 8'h5A);

    // R7: reset in the middle of a mismatching compare result
    drive(1'b0, 1'b1, 1'b1, 1'b1, 0, 8'h00);
    @(negedge clk);
    chk("R2 mismatch before reset", match, 0);
    rst = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 0, 0);
    @(negedge clk);
    chk("R7 match after reset", match, 1);
    chk("R7 dout_en after reset", dout_en, 0);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule